// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits beside the FIFO pair and the serial engine of an SPI controller. From the engine it takes the current transmit and receive FIFO fill levels, the strobes that push into and pop from those FIFOs, and a busy flag. From these it builds a 5-bit status word, a 5-bit raw interrupt vector, a masked copy of that vector, a single interrupt line, and two DMA request lines.

Software programs it through a small write port. The programmable items are:
- a level threshold for each FIFO, used for the interrupts;
- a data level for each FIFO, used for the DMA requests;
- an interrupt mask;
- a clear command;
- two DMA enables.

A level write that is equal to or above the FIFO depth is not kept. Software can therefore find the depth by writing growing values to the transmit threshold and reading it back. Two kinds of interrupt exist. The threshold interrupts are live levels. The overflow and underflow errors are sticky and stay set until a clear command removes them.

Top module: `spi_stat_irq`

## Requirements
- R1: The status word holds busy in bit 0, TX full in bit 1, TX empty in bit 2, RX empty in bit 3 and RX full in bit 4. A FIFO counts as full when its level equals the depth and as empty when its level is 0. The status word follows its inputs with no register in the path.
- R2: Raw interrupt bit 0 (TX below threshold) is high in every cycle in which the TX level is at or below the TX threshold. Raw interrupt bit 4 (RX above threshold) is high in every cycle in which the RX level is above the RX threshold.
- R3: Raw interrupt bit 1 (TX overflow) goes high in the cycle after a TX push made while the TX level equals the depth. It then stays high until it is cleared.
- R4: Raw interrupt bit 3 (RX overflow) goes high in the cycle after an RX push made at full. Raw interrupt bit 2 (RX underflow) goes high in the cycle after an RX pop made at level 0. Both bits stay high until they are cleared.
- R5: A write to the clear register (select 3) acts on each bit of write data [3:0] separately:
  - bit 0 clears all three sticky flags;
  - bit 1 clears RX underflow;
  - bit 2 clears RX overflow;
  - bit 3 clears TX overflow.

  A set event in the same cycle as a clear wins over the clear.
- R6: The masked vector is the raw vector ANDed with the mask register (select 2, write data [4:0]). The interrupt line is high exactly when at least one masked bit is high.
- R7: The four level registers are written through their selects: TX threshold 0, RX threshold 1, TX data level 5, RX data level 6. A write whose 8-bit data is equal to or above DEPTH leaves the register unchanged. The two thresholds can be read back on their own outputs.
- R8: The DMA enable register is select 4, with bit 0 for the RX enable and bit 1 for the TX enable. The TX request is high while the TX enable is set and the TX level is at or below the TX data level. The RX request is high while the RX enable is set and the RX level is above the RX data level.
- R9: After a synchronous reset the following hold:
  - all registers are 0 and the sticky flags are clear;
  - with both levels at 0, the status word is 5'b01100 and the raw vector is 5'b00001;
  - the masked vector, the interrupt line and both DMA requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| eng_busy | input | 1 | Serial engine busy flag |
| tx_level | input | LW | Current TX FIFO level |
| rx_level | input | LW | Current RX FIFO level |
| tx_push | input | 1 | Write into the TX FIFO |
| rx_push | input | 1 | Write into the RX FIFO |
| rx_pop | input | 1 | Read from the RX FIFO |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt vector |
| masked_irq | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt line |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| rd_tx_thr | output | LW | TX threshold readback |
| rd_rx_thr | output | LW | RX threshold readback |

## Verification
Both FIFO levels are swept through every value from 0 to the depth while the thresholds and data levels are set to mid values. This separates an at-or-below comparison from a strictly-above comparison at the exact boundary.

Pushes and pops are applied at the full and empty edges and again one entry inside them. This shows that only true overflow and underflow set the sticky flags. Clear commands are issued one bit at a time, as clear-all, and in the same cycle as a set event, which exposes a wrong bit-to-flag mapping or the wrong priority between set and clear.

Out-of-range level writes at the depth, at 31 and at 200 check that the old value is kept. Partial masks and a single DMA enable separate the masked vector from the raw vector and one DMA direction from the other.

// File: rtl/spi_si_pkg.sv
package spi_si_pkg;

    // register selects on the write port
    localparam logic [2:0] SEL_TX_THR = 3'd0;
    localparam logic [2:0] SEL_RX_THR = 3'd1;
    localparam logic [2:0] SEL_MASK   = 3'd2;
    localparam logic [2:0] SEL_CLEAR  = 3'd3;
    localparam logic [2:0] SEL_DMA_EN = 3'd4;
    localparam logic [2:0] SEL_TX_DL  = 3'd5;
    localparam logic [2:0] SEL_RX_DL  = 3'd6;

    localparam int NSRC    = 5;
    localparam int NSTICKY = 3;
    localparam int NLVL    = 4;

    // packed MSB first: bit 0 is busy
    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } status_t;

    // packed MSB first: bit 0 is TX below threshold
    typedef struct packed {
        logic rx_above;
        logic rx_ovf;
        logic rx_und;
        logic tx_ovf;
        logic tx_below;
    } irq_t;

    // sticky flag index: 0 TX overflow, 1 RX underflow, 2 RX overflow
    function automatic logic [NSTICKY-1:0] clr_decode(input logic [3:0] c);
        clr_decode[0] = c[0] | c[3];
        clr_decode[1] = c[0] | c[1];
        clr_decode[2] = c[0] | c[2];
    endfunction

    // level register index to its select value
    function automatic logic [2:0] lvl_sel(input int idx);
        case (idx)
            0:       lvl_sel = SEL_TX_THR;
            1:       lvl_sel = SEL_RX_THR;
            2:       lvl_sel = SEL_TX_DL;
            default: lvl_sel = SEL_RX_DL;
        endcase
    endfunction

endpackage

// File: rtl/si_cfg_regs.sv
module si_cfg_regs
    import spi_si_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [2:0]              sel,
    input  logic [7:0]              wdata,
    output logic [NLVL-1:0][LW-1:0] lvl_q,
    output logic [NSRC-1:0]         mask_q,
    output logic [1:0]              dma_en_q,
    output logic [3:0]              clr_cmd
);
    logic in_range;

    assign in_range = (wdata < 8'(DEPTH));

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_lvl
            always_ff @(posedge clk) begin
                if (rst)
                    lvl_q[g] <= '0;
                else if (wr && sel == lvl_sel(g) && in_range)
                    lvl_q[g] <= wdata[LW-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            dma_en_q <= '0;
        end else if (wr) begin
            if (sel == SEL_MASK)   mask_q   <= wdata[NSRC-1:0];
            if (sel == SEL_DMA_EN) dma_en_q <= wdata[1:0];
        end
    end

    assign clr_cmd = (wr && sel == SEL_CLEAR) ? wdata[3:0] : 4'd0;

endmodule

// File: rtl/si_sticky.sv
module si_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    q[g] <= 1'b0;
                else if (set[g])
                    q[g] <= 1'b1;   // set wins over clear
                else if (clr[g])
                    q[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/si_level_cmp.sv
module si_level_cmp #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] tx_thr,
    input  logic [LW-1:0] rx_thr,
    input  logic [LW-1:0] tx_dl,
    input  logic [LW-1:0] rx_dl,
    input  logic [1:0]    dma_en,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          tx_below,
    output logic          rx_above,
    output logic          tx_dreq,
    output logic          rx_dreq
);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

    assign tx_full  = (tx_level == FULL_L);
    assign rx_full  = (rx_level == FULL_L);
    assign tx_empty = (tx_level == '0);
    assign rx_empty = (rx_level == '0);
    assign tx_below = (tx_level <= tx_thr);
    assign rx_above = (rx_level >  rx_thr);
    assign tx_dreq  = dma_en[1] && (tx_level <= tx_dl);
    assign rx_dreq  = dma_en[0] && (rx_level >  rx_dl);
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
    import spi_si_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [7:0]    cfg_wdata,
    input  logic          eng_busy,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic          tx_push,
    input  logic          rx_push,
    input  logic          rx_pop,
    output logic [4:0]    status,
    output logic [4:0]    raw_irq,
    output logic [4:0]    masked_irq,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic [LW-1:0] rd_tx_thr,
    output logic [LW-1:0] rd_rx_thr
);
    logic [NLVL-1:0][LW-1:0] lvl_q;
    logic [NSRC-1:0]         mask_q;
    logic [1:0]              dma_en_q;
    logic [3:0]              clr_cmd;
    logic [NSTICKY-1:0]      err_set, err_q;
    logic tx_full, tx_empty, rx_full, rx_empty, tx_below, rx_above;
    status_t st;
    irq_t    raw;

    si_cfg_regs #(.DEPTH(DEPTH), .LW(LW)) u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .lvl_q(lvl_q), .mask_q(mask_q), .dma_en_q(dma_en_q), .clr_cmd(clr_cmd)
    );

    si_level_cmp #(.DEPTH(DEPTH), .LW(LW)) u_cmp (
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(lvl_q[0]), .rx_thr(lvl_q[1]), .tx_dl(lvl_q[2]), .rx_dl(lvl_q[3]),
        .dma_en(dma_en_q),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_below(tx_below), .rx_above(rx_above),
        .tx_dreq(tx_dma_req), .rx_dreq(rx_dma_req)
    );

    assign err_set[0] = tx_push && tx_full;
    assign err_set[1] = rx_pop  && rx_empty;
    assign err_set[2] = rx_push && rx_full;

    si_sticky #(.N(NSTICKY)) u_err (
        .clk(clk), .rst(rst), .set(err_set), .clr(clr_decode(clr_cmd)), .q(err_q)
    );

    always_comb begin
        st.busy     = eng_busy;
        st.tx_full  = tx_full;
        st.tx_empty = tx_empty;
        st.rx_empty = rx_empty;
        st.rx_full  = rx_full;
        raw.tx_below = tx_below;
        raw.tx_ovf   = err_q[0];
        raw.rx_und   = err_q[1];
        raw.rx_ovf   = err_q[2];
        raw.rx_above = rx_above;
    end

    assign status     = st;
    assign raw_irq    = raw;
    assign masked_irq = raw & mask_q;
    assign irq        = |masked_irq;
    assign rd_tx_thr  = lvl_q[0];
    assign rd_rx_thr  = lvl_q[1];

endmodule

// File: rtl/spi_stat_irq_chk.sv
module spi_stat_irq_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic [2:0]    cfg_sel,
    input logic [7:0]    cfg_wdata,
    input logic [LW-1:0] tx_level,
    input logic          tx_push,
    input logic [4:0]    status,
    input logic [4:0]    raw_irq,
    input logic [4:0]    masked_irq,
    input logic          tx_dma_req,
    input logic [LW-1:0] rd_tx_thr
);
    logic tx_at_full, clr_txovf;
    assign tx_at_full = (tx_level == LW'(DEPTH));
    assign clr_txovf  = cfg_wr && cfg_sel == 3'd3 && (cfg_wdata[0] || cfg_wdata[3]);

    AST_TXOVF_SET: assert property (@(posedge clk) disable iff (rst)
        tx_push && tx_at_full |=> raw_irq[1]);                                    // R3
    AST_TXOVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        raw_irq[1] && !clr_txovf |=> raw_irq[1]);                                 // R3
    AST_TXOVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_txovf && !(tx_push && tx_at_full) |=> !raw_irq[1]);                   // R5
    AST_THR_KEEP: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && cfg_sel == 3'd0 && cfg_wdata >= 8'(DEPTH) |=> $stable(rd_tx_thr)); // R7
    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (masked_irq & ~raw_irq) == 5'd0);                                         // R6
    AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(status[1] && status[2]));                                               // R1
    AST_TXDMA_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> !status[1]);                                               // R8
endmodule

bind spi_stat_irq spi_stat_irq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tx_level(tx_level), .tx_push(tx_push), .status(status), .raw_irq(raw_irq),
    .masked_irq(masked_irq), .tx_dma_req(tx_dma_req), .rd_tx_thr(rd_tx_thr)
);

// File: tb/spi_stat_irq_bench.sv
module spi_stat_irq_bench;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [7:0]    cfg_wdata = 8'd0;
    logic          eng_busy = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic [LW-1:0] rx_level = '0;
    logic          tx_push = 1'b0;
    logic          rx_push = 1'b0;
    logic          rx_pop = 1'b0;
    logic [4:0]    status, raw_irq, masked_irq;
    logic          irq, tx_dma_req, rx_dma_req;
    logic [LW-1:0] rd_tx_thr, rd_rx_thr;

    int n_checks = 0;
    int n_bad = 0;

    // reference state
    int m_txthr, m_rxthr, m_txdl, m_rxdl, m_mask, m_dma;
    bit m_txovf, m_rxund, m_rxovf;

    always #4 clk = ~clk;  // 125 MHz

    spi_stat_irq #(.DEPTH(DEPTH)) u_spi_stat_irq (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .eng_busy(eng_busy), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
        .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .rd_tx_thr(rd_tx_thr), .rd_rx_thr(rd_rx_thr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        if (rst) begin
            m_txthr = 0; m_rxthr = 0; m_txdl = 0; m_rxdl = 0;
            m_mask = 0; m_dma = 0;
            m_txovf = 0; m_rxund = 0; m_rxovf = 0;
        end else begin
            if (cfg_wr) begin
                case (cfg_sel)
                    3'd0: if (cfg_wdata < DEPTH) m_txthr = cfg_wdata;
                    3'd1: if (cfg_wdata < DEPTH) m_rxthr = cfg_wdata;
                    3'd2: m_mask = cfg_wdata & 8'h1f;
                    3'd3: begin
                        if (cfg_wdata[0] || cfg_wdata[3]) m_txovf = 0;
                        if (cfg_wdata[0] || cfg_wdata[1]) m_rxund = 0;
                        if (cfg_wdata[0] || cfg_wdata[2]) m_rxovf = 0;
                    end
                    3'd4: m_dma = cfg_wdata & 8'h03;
                    3'd5: if (cfg_wdata < DEPTH) m_txdl = cfg_wdata;
                    3'd6: if (cfg_wdata < DEPTH) m_rxdl = cfg_wdata;
                    default: ;
                endcase
            end
            if (tx_push && tx_level == DEPTH) m_txovf = 1;
            if (rx_pop  && rx_level == 0)     m_rxund = 1;
            if (rx_push && rx_level == DEPTH) m_rxovf = 1;
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        int e_st, e_raw, e_msk;
        #2;
        if (!rst) begin
            e_st  = (eng_busy ? 1 : 0) | ((tx_level == DEPTH) ? 2 : 0) | ((tx_level == 0) ? 4 : 0)
                  | ((rx_level == 0) ? 8 : 0) | ((rx_level == DEPTH) ? 16 : 0);
            e_raw = ((tx_level <= m_txthr) ? 1 : 0) | (m_txovf ? 2 : 0) | (m_rxund ? 4 : 0)
                  | (m_rxovf ? 8 : 0) | ((rx_level > m_rxthr) ? 16 : 0);
            e_msk = e_raw & m_mask;
            chk("R1 status", status, e_st);
            chk("R2 threshold irq bits", raw_irq & 5'h11, e_raw & 'h11);
            chk("R3 tx overflow bit", raw_irq[1], (e_raw >> 1) & 1);
            chk("R4 rx error bits", (raw_irq >> 2) & 3, (e_raw >> 2) & 3);
            chk("R6 masked", masked_irq, e_msk);
            chk("R6 irq line", irq, (e_msk != 0) ? 1 : 0);
            chk("R7 tx thr readback", rd_tx_thr, m_txthr);
            chk("R7 rx thr readback", rd_rx_thr, m_rxthr);
            chk("R8 tx dma", tx_dma_req, (m_dma[1] && tx_level <= m_txdl) ? 1 : 0);
            chk("R8 rx dma", rx_dma_req, (m_dma[0] && rx_level > m_rxdl) ? 1 : 0);
        end
    end

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic lv(input int t, input int r);
        @(negedge clk);
        tx_level = LW'(t); rx_level = LW'(r);
    endtask

    task automatic strobe(input bit tp, input bit rp, input bit ro);
        @(negedge clk);
        tx_push = tp; rx_push = rp; rx_pop = ro;
        @(negedge clk);
        tx_push = 0; rx_push = 0; rx_pop = 0;
    endtask

    initial begin
        #400000;
        n_checks++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 status", status, 5'b01100);
        chk("R9 raw", raw_irq, 5'b00001);
        chk("R9 masked", masked_irq, 0);
        chk("R9 dma", {tx_dma_req, rx_dma_req}, 0);
        chk("R9 thr", rd_tx_thr, 0);

        // R2 threshold sweep
        wr(0, 8); wr(1, 7);
        for (int i = 0; i <= DEPTH; i++) lv(i, DEPTH - i);
        wr(2, 5'h1f);
        // R3 / R4 edges
        lv(DEPTH - 1, DEPTH - 1); strobe(1, 1, 0);
        lv(1, 1);                 strobe(0, 0, 1);
        lv(DEPTH, DEPTH);         strobe(1, 1, 0);
        lv(0, 0);                 strobe(0, 0, 1);
        lv(5, 5); eng_busy = 1;
        // R5 per-bit clears
        wr(3, 4'b1000); wr(3, 4'b0100); wr(3, 4'b0010);
        lv(DEPTH, 0); strobe(1, 0, 1);
        wr(3, 4'b0001);
        @(negedge clk);
        chk("R5 clear all", raw_irq & 5'b01110, 0);
        // R5 set wins over clear in same cycle
        @(negedge clk);
        tx_push = 1; cfg_wr = 1; cfg_sel = 3'd3; cfg_wdata = 8'h09;
        @(negedge clk);
        tx_push = 0; cfg_wr = 0;
        chk("R5 set beats clear", raw_irq[1], 1);
        // R6 partial mask
        wr(2, 5'b01010); lv(0, DEPTH); lv(9, 3);
        wr(2, 0);
        eng_busy = 0;
        // R7 out of range writes
        wr(0, DEPTH); wr(0, 31); wr(0, 200); wr(1, DEPTH - 1); wr(1, DEPTH);
        @(negedge clk);
        chk("R7 tx thr kept", rd_tx_thr, 8);
        // R8 DMA
        wr(4, 3); wr(5, 4); wr(6, 2); wr(5, DEPTH);
        for (int i = 0; i <= DEPTH; i++) lv(i, i);
        wr(4, 1);
        for (int i = 0; i <= DEPTH; i += 3) lv(DEPTH - i, i);
        wr(4, 2); lv(2, 9); lv(7, 0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule